// File: doc/BRIEF.md
# Unlock Command Sequence Decoder

This block watches every bus write cycle, given as an address and a data byte, and picks out the multi-byte unlock commands of a byte-wide page-write nonvolatile memory. All of these commands begin with the same two-byte key. A third byte then either completes a short command or leads into a longer six-byte form. The block keeps two flags for the whole device: write protection and identification mode. It also issues one-cycle start pulses to the page buffer, to the erase sequencer and to the protection-clear logic. While identification mode is active, it answers reads with the maker and device codes.

Page-load windows are also handled here. A window opens either after the protected page-write command or, when protection is off, on any plain write. It stays open while data writes keep arriving within `LOAD_CYCLES` of each other. A plain write made while protection is on is refused. The block then stays busy for `LOCKOUT_CYCLES` cycles and ignores every write cycle during that time.

Top module: `unlock_seq_decoder`

## Requirements
- R1: With protection off, a write in idle that is not the first key byte pulses `page_open_o` and `page_wr_o` together. Each later write that arrives within `LOAD_CYCLES` idle cycles of the previous one pulses only `page_wr_o`. After more than `LOAD_CYCLES` cycles with no write, the window closes and the next write is judged afresh.
- R2: The three writes AAh@5555h, 55h@2AAAh, A0h@5555h set `prot_en_o` and pulse `page_open_o` on the third write. None of the three command writes pulses `page_wr_o`. Writes that follow within the window pulse `page_wr_o`.
- R3: Key then 90h@5555h sets `id_mode_o`. Key, 80h@5555h, key again, then 60h@5555h also sets it. Key then F0h@5555h clears it. `id_mode_o` changes only in the cycle after a write.
- R4: A read pulse in identification mode gives `id_valid_o` one cycle later, with `id_data_o` = BFh when address bit 0 is 0 and 07h when it is 1. Outside identification mode, `id_valid_o` stays low.
- R5: Key, 80h@5555h, key, 10h@5555h pulses `erase_start_o` and leaves `prot_en_o` unchanged.
- R6: Key, 80h@5555h, key, 20h@5555h pulses `unprot_start_o` and clears `prot_en_o`.
- R7: Only address bits 14..0 are compared. Bits 16..15 may take any value. A key data byte at an address that differs in bit 14 is not a key write.
- R8: A write that does not match the expected step returns the decoder to idle, and that same write is judged as a first step. It may start a new key, open a window when protection is off, or be refused when protection is on.
- R9: With protection on, a write judged in idle that is not a key byte pulses `wr_reject_o`, and `busy_o` rises in the same cycle and stays high for `LOCKOUT_CYCLES` cycles.
- R10: Write cycles while `busy_o` is high are ignored. They emit no pulse and do not advance a sequence.
- R11: After reset, `prot_en_o`, `id_mode_o`, `busy_o` and every pulse output are low.
- R12: All pulse outputs are registered and appear in the cycle after the write that causes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | One write cycle this clock |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | 8 | Write data |
| rd_valid_i | input | 1 | One read cycle this clock |
| rd_addr_i | input | ADDR_W | Read address (bit 0 selects ID byte) |
| prot_en_o | output | 1 | Global write protection flag |
| id_mode_o | output | 1 | Identification mode flag |
| busy_o | output | 1 | Lockout after a refused write |
| page_open_o | output | 1 | Pulse: page-load window opened |
| page_wr_o | output | 1 | Pulse: this write is page data |
| erase_start_o | output | 1 | Pulse: start chip erase |
| unprot_start_o | output | 1 | Pulse: protection cleared |
| wr_reject_o | output | 1 | Pulse: write refused under protection |
| id_valid_o | output | 1 | ID byte on `id_data_o` is valid |
| id_data_o | output | 8 | ID byte |

## Verification
The assertions watch several rules on every cycle. A refusal always coincides with busy and with protection on. A protection-clear pulse leaves the flag low. At most one kind of command pulse fires at a time. The lockout and window counters count down one per cycle. The mode flag moves only after a write, and no write cycle moves the sequence state while the block is busy. Other behaviour can only be shown by the scoreboard scenarios. These include the exact code values and addresses each command needs, and the don't-care upper address bits against the compared bit 14. They also include re-judging a breaking write, and window closure after idle time. The last is the ID bytes returned for each address parity.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int CMP_W = 15;

  localparam logic [CMP_W-1:0] ADDR_KA = 15'h5555;
  localparam logic [CMP_W-1:0] ADDR_KB = 15'h2AAA;

  localparam logic [7:0] KEY_1      = 8'hAA;
  localparam logic [7:0] KEY_2      = 8'h55;
  localparam logic [7:0] CMD_PAGE   = 8'hA0;
  localparam logic [7:0] CMD_ID_IN  = 8'h90;
  localparam logic [7:0] CMD_ID_OUT = 8'hF0;
  localparam logic [7:0] CMD_EXT    = 8'h80;
  localparam logic [7:0] EXT_ERASE  = 8'h10;
  localparam logic [7:0] EXT_UNPROT = 8'h20;
  localparam logic [7:0] EXT_ID_IN  = 8'h60;

  localparam logic [7:0] ID_MAKER  = 8'hBF;
  localparam logic [7:0] ID_DEVICE = 8'h07;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_K1,
    ST_K2,
    ST_X3,
    ST_X4,
    ST_X5,
    ST_LOAD
  } seq_state_e;
endpackage

// File: rtl/useq_timer.sv
module useq_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic active_o
);
  localparam int W = $clog2(LIMIT + 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= W'(LIMIT);
    else if (cnt_q != '0)      cnt_q <= cnt_q - W'(1);
  end

  assign active_o = (cnt_q != '0);

  p_count_down_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0 && !load_i) |=> (cnt_q == $past(cnt_q) - W'(1)));

  p_load_full_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == W'(LIMIT)));
endmodule

// File: rtl/useq_fsm.sv
module useq_fsm
  import useq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_valid_i,
  input  logic [CMP_W-1:0] wr_addr_i,
  input  logic [7:0]       wr_data_i,
  input  logic             busy_i,
  input  logic             win_active_i,
  output logic             win_load_o,
  output logic             reject_now_o,
  output logic             prot_o,
  output logic             id_mode_o,
  output logic             page_open_o,
  output logic             page_wr_o,
  output logic             erase_o,
  output logic             unprot_o,
  output logic             reject_o
);
  seq_state_e state_q, state_n;
  logic prot_q, prot_n, id_q, id_n;
  logic open_n, wr_n, erase_n, unprot_n, rej_n;
  logic fire, hit_k1, hit_k2, at_ka, use_judge;

  // Judgment of a write taken as a first step
  seq_state_e j_state;
  logic j_open, j_rej;

  assign fire   = wr_valid_i & ~busy_i;
  assign at_ka  = (wr_addr_i == ADDR_KA);
  assign hit_k1 = at_ka && (wr_data_i == KEY_1);
  assign hit_k2 = (wr_addr_i == ADDR_KB) && (wr_data_i == KEY_2);

  always_comb begin
    j_open  = 1'b0;
    j_rej   = 1'b0;
    j_state = ST_IDLE;
    if (hit_k1) begin
      j_state = ST_K1;
    end else if (!prot_q) begin
      j_state = ST_LOAD;
      j_open  = 1'b1;
    end else begin
      j_rej = 1'b1;
    end
  end

  always_comb begin
    state_n    = state_q;
    prot_n     = prot_q;
    id_n       = id_q;
    open_n     = 1'b0;
    wr_n       = 1'b0;
    erase_n    = 1'b0;
    unprot_n   = 1'b0;
    rej_n      = 1'b0;
    win_load_o = 1'b0;
    use_judge  = 1'b0;
    if (fire) begin
      unique case (state_q)
        ST_IDLE: use_judge = 1'b1;
        ST_K1: begin
          if (hit_k2) state_n = ST_K2;
          else        use_judge = 1'b1;
        end
        ST_K2: begin
          if (!at_ka) begin
            use_judge = 1'b1;
          end else begin
            unique case (wr_data_i)
              CMD_PAGE: begin
                prot_n     = 1'b1;
                open_n     = 1'b1;
                win_load_o = 1'b1;
                state_n    = ST_LOAD;
              end
              CMD_ID_IN:  begin id_n = 1'b1; state_n = ST_IDLE; end
              CMD_ID_OUT: begin id_n = 1'b0; state_n = ST_IDLE; end
              CMD_EXT:    state_n = ST_X3;
              default:    use_judge = 1'b1;
            endcase
          end
        end
        ST_X3: begin
          if (hit_k1) state_n = ST_X4;
          else        use_judge = 1'b1;
        end
        ST_X4: begin
          if (hit_k2) state_n = ST_X5;
          else        use_judge = 1'b1;
        end
        ST_X5: begin
          if (!at_ka) begin
            use_judge = 1'b1;
          end else begin
            unique case (wr_data_i)
              EXT_ERASE:  begin erase_n = 1'b1; state_n = ST_IDLE; end
              EXT_UNPROT: begin unprot_n = 1'b1; prot_n = 1'b0; state_n = ST_IDLE; end
              EXT_ID_IN:  begin id_n = 1'b1; state_n = ST_IDLE; end
              default:    use_judge = 1'b1;
            endcase
          end
        end
        ST_LOAD: begin
          wr_n       = 1'b1;
          win_load_o = 1'b1;
        end
        default: state_n = ST_IDLE;
      endcase
      if (use_judge) begin
        state_n    = j_state;
        open_n     = j_open;
        wr_n       = j_open;
        win_load_o = j_open;
        rej_n      = j_rej;
      end
    end else if (state_q == ST_LOAD && !win_active_i) begin
      state_n = ST_IDLE;
    end
  end

  assign reject_now_o = rej_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      prot_q      <= 1'b0;
      id_q        <= 1'b0;
      page_open_o <= 1'b0;
      page_wr_o   <= 1'b0;
      erase_o     <= 1'b0;
      unprot_o    <= 1'b0;
      reject_o    <= 1'b0;
    end else begin
      state_q     <= state_n;
      prot_q      <= prot_n;
      id_q        <= id_n;
      page_open_o <= open_n;
      page_wr_o   <= wr_n;
      erase_o     <= erase_n;
      unprot_o    <= unprot_n;
      reject_o    <= rej_n;
    end
  end

  assign prot_o    = prot_q;
  assign id_mode_o = id_q;

  p_busy_freezes_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && wr_valid_i) |=> (state_q == $past(state_q)));

  p_id_moves_on_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_valid_i |=> (id_q == $past(id_q)));

  p_erase_keeps_prot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_o |-> (prot_q == $past(prot_q)));
endmodule

// File: rtl/useq_id_resp.sv
module useq_id_resp
  import useq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       id_mode_i,
  input  logic       rd_valid_i,
  input  logic       rd_lsb_i,
  output logic       id_valid_o,
  output logic [7:0] id_data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      id_valid_o <= 1'b0;
      id_data_o  <= 8'h00;
    end else begin
      id_valid_o <= rd_valid_i & id_mode_i;
      if (rd_valid_i && id_mode_i) id_data_o <= rd_lsb_i ? ID_DEVICE : ID_MAKER;
    end
  end
endmodule

// File: rtl/unlock_seq_decoder.sv
module unlock_seq_decoder
  import useq_pkg::*;
#(
  parameter int ADDR_W         = 17,
  parameter int LOCKOUT_CYCLES = 16,
  parameter int LOAD_CYCLES    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              rd_valid_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              prot_en_o,
  output logic              id_mode_o,
  output logic              busy_o,
  output logic              page_open_o,
  output logic              page_wr_o,
  output logic              erase_start_o,
  output logic              unprot_start_o,
  output logic              wr_reject_o,
  output logic              id_valid_o,
  output logic [7:0]        id_data_o
);
  logic win_load, win_active, reject_now;

  // Upper address bits are don't-care by definition
  logic unused_hi;
  assign unused_hi = ^{wr_addr_i[ADDR_W-1:CMP_W], rd_addr_i[ADDR_W-1:1]};

  useq_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_valid_i  (wr_valid_i),
    .wr_addr_i   (wr_addr_i[CMP_W-1:0]),
    .wr_data_i   (wr_data_i),
    .busy_i      (busy_o),
    .win_active_i(win_active),
    .win_load_o  (win_load),
    .reject_now_o(reject_now),
    .prot_o      (prot_en_o),
    .id_mode_o   (id_mode_o),
    .page_open_o (page_open_o),
    .page_wr_o   (page_wr_o),
    .erase_o     (erase_start_o),
    .unprot_o    (unprot_start_o),
    .reject_o    (wr_reject_o)
  );

  useq_timer #(.LIMIT(LOCKOUT_CYCLES)) u_lockout (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (reject_now),
    .active_o(busy_o)
  );

  useq_timer #(.LIMIT(LOAD_CYCLES)) u_window (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (win_load),
    .active_o(win_active)
  );

  useq_id_resp u_id (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .id_mode_i (id_mode_o),
    .rd_valid_i(rd_valid_i),
    .rd_lsb_i  (rd_addr_i[0]),
    .id_valid_o(id_valid_o),
    .id_data_o (id_data_o)
  );

  p_reject_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_reject_o |-> (busy_o && prot_en_o));

  p_unprot_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unprot_start_o |-> !prot_en_o);

  p_one_cmd_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({page_open_o, erase_start_o, unprot_start_o, wr_reject_o}));

  p_id_only_in_mode_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_i && !id_mode_o) |=> !id_valid_o);
endmodule

// File: tb/unlock_seq_decoder_tb.sv
module unlock_seq_decoder_tb;
  localparam int AW = 17;
  localparam logic [4:0] EV_NO = 5'b00000;
  localparam logic [4:0] EV_OW = 5'b11000;
  localparam logic [4:0] EV_WR = 5'b01000;
  localparam logic [4:0] EV_OP = 5'b10000;
  localparam logic [4:0] EV_ER = 5'b00100;
  localparam logic [4:0] EV_PD = 5'b00010;
  localparam logic [4:0] EV_RJ = 5'b00001;
  localparam logic [AW-1:0] KA  = 17'h05555;
  localparam logic [AW-1:0] KB  = 17'h02AAA;
  localparam logic [AW-1:0] KAH = 17'h1D555;
  localparam logic [AW-1:0] KBH = 17'h1AAAA;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0, rd_valid = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic prot, idm, busy, p_open, p_wr, er, unp, rej, idv;
  logic [7:0] idd;
  logic wr_seen;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [4:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  unlock_seq_decoder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_valid), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_valid_i(rd_valid), .rd_addr_i(rd_addr),
    .prot_en_o(prot), .id_mode_o(idm), .busy_o(busy), .page_open_o(p_open),
    .page_wr_o(p_wr), .erase_start_o(er), .unprot_start_o(unp),
    .wr_reject_o(rej), .id_valid_o(idv), .id_data_o(idd)
  );

  always @(posedge clk or negedge rst_n)
    if (!rst_n) wr_seen <= 1'b0;
    else        wr_seen <= wr_valid;

  // Monitor: compares pulse outputs against the scoreboard queue
  always @(negedge clk) begin
    logic [4:0] got;
    got = {p_open, p_wr, er, unp, rej};
    if (rst_n && wr_seen) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R12: pulse %b with empty queue, expected none", got);
      end else begin
        logic [4:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (got !== e) begin
          errors++;
          $display("FAIL %s: pulses %b expected %b", t, got, e);
        end
      end
    end else if (rst_n && got != 5'b0) begin
      checks++;
      errors++;
      $display("FAIL R12: spurious pulses %b expected 00000", got);
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d,
                    input logic [4:0] ev, input string tag);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    exp_q.push_back(ev); tag_q.push_back(tag);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic v, input logic [7:0] d,
                    input string tag);
    @(negedge clk);
    rd_valid = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_valid = 1'b0;
    chk(tag, {7'b0, idv}, {7'b0, v});
    if (v) chk(tag, idd, d);
  endtask

  task automatic key(input string tag);
    wr(KA, 8'hAA, EV_NO, tag);
    wr(KB, 8'h55, EV_NO, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R11 reset state
    chk("R11 prot", {7'b0, prot}, 8'h0);
    chk("R11 id",   {7'b0, idm},  8'h0);
    chk("R11 busy", {7'b0, busy}, 8'h0);

    // R1 unprotected plain writes and window timeout
    wr(17'h00123, 8'h11, EV_OW, "R1 open");
    idle(5);
    wr(17'h00124, 8'h22, EV_WR, "R1 in window");
    idle(12);
    wr(17'h00200, 8'h33, EV_OW, "R1 reopen after timeout");
    idle(12);

    // R7 bit 14 differs: not a key, plain write
    wr(17'h01555, 8'hAA, EV_OW, "R7 bit14");
    idle(12);

    // R2 with don't-care upper bits (R7)
    wr(KAH, 8'hAA, EV_NO, "R7 upper bits");
    wr(KBH, 8'h55, EV_NO, "R7 upper bits");
    wr(KA, 8'hA0, EV_OP, "R2 page cmd");
    chk("R2 prot set", {7'b0, prot}, 8'h1);
    wr(17'h00300, 8'h01, EV_WR, "R2 data");
    wr(17'h00301, 8'h02, EV_WR, "R2 data");
    idle(12);

    // R9 refusal and lockout, R10 writes ignored
    wr(17'h00400, 8'h05, EV_RJ, "R9 refuse");
    chk("R9 busy", {7'b0, busy}, 8'h1);
    wr(KA, 8'hAA, EV_NO, "R10 ignored");
    idle(20);
    chk("R9 busy ends", {7'b0, busy}, 8'h0);
    wr(KB, 8'h55, EV_RJ, "R10 no advance");
    idle(20);

    // R3 / R4 ID mode
    key("R3");
    wr(KA, 8'h90, EV_NO, "R3 id entry");
    chk("R3 id on", {7'b0, idm}, 8'h1);
    rd(17'h00000, 1'b1, 8'hBF, "R4 maker");
    rd(17'h1FFFF, 1'b1, 8'h07, "R4 device");
    key("R3");
    wr(KA, 8'hF0, EV_NO, "R3 id exit");
    chk("R3 id off", {7'b0, idm}, 8'h0);
    rd(17'h00000, 1'b0, 8'h00, "R4 no id");

    // R3 alternate six-byte entry
    key("R3");
    wr(KA, 8'h80, EV_NO, "R3 ext");
    key("R3");
    wr(KA, 8'h60, EV_NO, "R3 alt id");
    chk("R3 alt id on", {7'b0, idm}, 8'h1);
    key("R3");
    wr(KA, 8'hF0, EV_NO, "R3 exit");
    chk("R3 exit", {7'b0, idm}, 8'h0);

    // R8 breaking write restarts as key
    wr(KA, 8'hAA, EV_NO, "R8");
    wr(KA, 8'hAA, EV_NO, "R8 restart");
    wr(KB, 8'h55, EV_NO, "R8");
    wr(KA, 8'h90, EV_NO, "R8");
    chk("R8 restart id", {7'b0, idm}, 8'h1);
    key("R8");
    wr(KA, 8'hF0, EV_NO, "R8");

    // R8 bad third byte under protection is refused
    key("R8");
    wr(KA, 8'h33, EV_RJ, "R8 bad cmd refused");
    idle(20);

    // R5 chip erase
    key("R5");
    wr(KA, 8'h80, EV_NO, "R5");
    key("R5");
    wr(KA, 8'h10, EV_ER, "R5 erase");
    chk("R5 prot kept", {7'b0, prot}, 8'h1);

    // R6 protection disable
    key("R6");
    wr(KA, 8'h80, EV_NO, "R6");
    key("R6");
    wr(KA, 8'h20, EV_PD, "R6 unprot");
    chk("R6 prot cleared", {7'b0, prot}, 8'h0);
    wr(17'h00500, 8'h09, EV_OW, "R6 plain ok");
    idle(12);

    // R8 unprotected break opens a window
    wr(KA, 8'hAA, EV_NO, "R8");
    wr(17'h00600, 8'h77, EV_OW, "R8 break opens");
    idle(12);

    chk("R12 queue drained", 8'(exp_q.size()), 8'h0);
    finish_run();
  end
endmodule